// File: doc/BRIEF.md
# JTAG TAP State Navigator

This block is a JTAG master front end that steers an external test access port from whatever state it is in to a state that a controller asks for. It keeps its own copy of the 16-state TAP controller and advances that copy on every TCK it issues, using the TMS value it drove. A small step table, with one 16-bit row per current state, supplies the TMS value for the next move toward any target. The block therefore walks the port one TCK at a time without computing a route at run time.

Two commands are accepted: "go to state S", and "dwell in stable state S for N clocks". After reset the block does not know what state the port is in. The first command is therefore preceded by a fixed resynchronisation burst. TCK comes from a simple clock-enable divider of the system clock. TMS is only updated while TCK is low, and TDI is held at zero because this block does no data shifting.

Top module: `tap_walker`

## Requirements
- R1: The first command after reset is preceded by five TCKs with TMS high and then one TCK with TMS low. This burst leaves the tracked state at Run-Test/Idle, and it is not repeated for later commands.
- R2: State codes are Reset=0, Idle=1, Select-DR=2, Capture-DR=3, Shift-DR=4, Exit1-DR=5, Pause-DR=6, Exit2-DR=7, Update-DR=8, Select-IR=9, Capture-IR=10, Shift-IR=11, Exit1-IR=12, Pause-IR=13, Exit2-IR=14, Update-IR=15. Each routing step drives TMS equal to bit `target` of the step-table row for the current state. For example, Idle to Shift-DR is TMS 1,0,0, and Exit1-DR to Reset is TMS 1,1,1,1.
- R3: For every target, a go-to command leaves the port in that target after at most 9 routing TCKs. The tracked state follows the standard TAP transition for each TMS value driven.
- R4: If the target has not been reached after MAX_STEPS routing TCKs (default 9), routing stops and `err` is high in the cycle `done` pulses. `err` is cleared when the next command is accepted.
- R5: A go-to command whose target is Idle, Shift-DR, Pause-DR, Shift-IR or Pause-IR, when the port is already in that state, issues exactly one TCK with TMS low.
- R6: A go-to Reset when the port is already in Reset issues exactly one TCK with TMS high.
- R7: A go-to command for any other state the port is already in issues no TCK and still completes with `done`.
- R8: A dwell command first routes to its state without the extra clock of R5 or R6. It then issues exactly `cmd_cycles` TCKs, with TMS high when the state is Reset and low otherwise. A count of zero issues no dwell clock.
- R9: TDI is low at every TCK rising edge.
- R10: TCK idles low, each TCK high phase lasts HALF_DIV clock cycles, and TMS never changes while TCK is high.
- R11: `busy` is high from command acceptance until `done`. `done` is a one-cycle pulse, and a command presented while busy is ignored.
- R12: Out of reset, `tck`, `tms`, `tdi`, `busy`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_wait | input | 1 | 0 = go to state, 1 = dwell in state |
| cmd_target | input | 4 | Target state code (R2 encoding) |
| cmd_cycles | input | CYC_W | Dwell TCK count for a dwell command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Target not reached within the step limit |
| tck | output | 1 | Test clock to the port |
| tms | output | 1 | Test mode select to the port |
| tdi | output | 1 | Test data in, held low |

## Verification
The bench models the port on its own from the TCK and TMS pins and starts it in an arbitrary state. A design that skipped or shortened the resync burst would therefore land in the wrong state and fail the first sequence check. The repeated same-state commands target the three dwell classes: a stable state, Reset, and a transient state. A design that clocked a transient state, or used the wrong TMS level for Reset, would show the wrong TCK count or pattern. Dwell commands are checked with counts of zero and non-zero, in Reset and in other states, so an off-by-one loop counter or an extra navigation clock shows up. A second instance with a step limit of two checks that routing stops and flags an error, and that the next command clears the flag.

// File: rtl/tap_walker_pkg.sv
`timescale 1ns/1ps
package tap_walker_pkg;

  // Code order matters: it indexes the rows and bits of the step table.
  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE, TS_DSEL, TS_DCAP, TS_DSHF, TS_DEX1, TS_DPAU, TS_DEX2,
    TS_DUPD,  TS_ISEL, TS_ICAP, TS_ISHF, TS_IEX1, TS_IPAU, TS_IEX2, TS_IUPD
  } tap_st_e;

  // Standard TAP controller transition for one TCK.
  function automatic tap_st_e tap_next(tap_st_e s, logic tms);
    tap_st_e n;
    case (s)
      TS_RESET: n = tms ? TS_RESET : TS_IDLE;
      TS_IDLE:  n = tms ? TS_DSEL  : TS_IDLE;
      TS_DSEL:  n = tms ? TS_ISEL  : TS_DCAP;
      TS_DCAP:  n = tms ? TS_DEX1  : TS_DSHF;
      TS_DSHF:  n = tms ? TS_DEX1  : TS_DSHF;
      TS_DEX1:  n = tms ? TS_DUPD  : TS_DPAU;
      TS_DPAU:  n = tms ? TS_DEX2  : TS_DPAU;
      TS_DEX2:  n = tms ? TS_DUPD  : TS_DSHF;
      TS_DUPD:  n = tms ? TS_DSEL  : TS_IDLE;
      TS_ISEL:  n = tms ? TS_RESET : TS_ICAP;
      TS_ICAP:  n = tms ? TS_IEX1  : TS_ISHF;
      TS_ISHF:  n = tms ? TS_IEX1  : TS_ISHF;
      TS_IEX1:  n = tms ? TS_IUPD  : TS_IPAU;
      TS_IPAU:  n = tms ? TS_IEX2  : TS_IPAU;
      TS_IEX2:  n = tms ? TS_IUPD  : TS_ISHF;
      default:  n = tms ? TS_DSEL  : TS_IDLE;
    endcase
    return n;
  endfunction

  // One row per current state; bit t = TMS for the next step toward t.
  function automatic logic [15:0] steer_row(tap_st_e s);
    logic [15:0] r;
    case (s)
      TS_RESET: r = 16'h0001;
      TS_IDLE:  r = 16'hFFFD;
      TS_DSEL:  r = 16'hFE01;
      TS_DCAP:  r = 16'hFFE7;
      TS_DSHF:  r = 16'hFFEF;
      TS_DEX1:  r = 16'hFF0F;
      TS_DPAU:  r = 16'hFFBF;
      TS_DEX2:  r = 16'hFFFF;
      TS_DUPD:  r = 16'hFEFD;
      TS_ISEL:  r = 16'h0001;
      TS_ICAP:  r = 16'hF3FF;
      TS_ISHF:  r = 16'hF7FF;
      TS_IEX1:  r = 16'h87FF;
      TS_IPAU:  r = 16'hDFFF;
      TS_IEX2:  r = 16'hFFFF;
      default:  r = 16'h7FFD;
    endcase
    return r;
  endfunction

  // States that loop on TMS low and get one extra clock on a same-state go-to.
  function automatic logic holds_low(tap_st_e s);
    return (s == TS_IDLE) || (s == TS_DSHF) || (s == TS_DPAU) ||
           (s == TS_ISHF) || (s == TS_IPAU);
  endfunction

endpackage

// File: rtl/tap_tck_engine.sv
`timescale 1ns/1ps
module tap_tck_engine #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_go,
  input  logic bit_tms,
  output logic tck,
  output logic tms,
  output logic bit_busy,
  output logic bit_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  typedef enum logic [1:0] {PH_OFF, PH_LOW, PH_HIGH} phase_e;
  phase_e ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_OFF;
      cnt     <= '0;
      tck     <= 1'b0;
      tms     <= 1'b0;
      bit_end <= 1'b0;
    end else begin
      bit_end <= 1'b0;
      case (ph)
        PH_OFF: if (bit_go) begin
          tms <= bit_tms;
          ph  <= PH_LOW;
          cnt <= '0;
        end
        PH_LOW: if (cnt == LAST) begin
          tck <= 1'b1;
          ph  <= PH_HIGH;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == LAST) begin
          tck     <= 1'b0;
          bit_end <= 1'b1;
          ph      <= PH_OFF;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assign bit_busy = (ph != PH_OFF);

  // TMS may only move while TCK is, and was, low.
  assert_tms_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tms) |-> (!tck && !$past(tck)));
endmodule

// File: rtl/tap_track.sv
`timescale 1ns/1ps
module tap_track
  import tap_walker_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step,
  input  logic    step_tms,
  input  logic    mark_known,
  output tap_st_e cur,
  output logic    known
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= TS_RESET;
      known <= 1'b0;
    end else begin
      if (step)       cur   <= tap_next(cur, step_tms);
      if (mark_known) known <= 1'b1;
    end
  end

  // The resync burst must leave the copy in Run-Test/Idle.
  assert_sync_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(known) |-> (cur == TS_IDLE));
endmodule

// File: rtl/tap_seq.sv
`timescale 1ns/1ps
module tap_seq
  import tap_walker_pkg::*;
#(
  parameter int MAX_STEPS = 9,
  parameter int CYC_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_wait,
  input  logic [3:0]       cmd_target,
  input  logic [CYC_W-1:0] cmd_cycles,
  input  tap_st_e          cur,
  input  logic             known,
  input  logic             bit_end,
  input  logic             bit_busy,
  input  logic             tck,
  output logic             bit_go,
  output logic             bit_tms,
  output logic             mark_known,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int SW = $clog2(MAX_STEPS + 1);
  localparam logic [SW-1:0] STEP_CAP = SW'(MAX_STEPS);
  localparam logic [2:0] SYNC_LAST = 3'd5;

  typedef enum logic [2:0] {
    F_IDLE, F_SYNC, F_SYNC_W, F_CHECK, F_ROUTE, F_ROUTE_W, F_LOOP, F_LOOP_W
  } fsm_e;
  fsm_e fsm;
  logic             fin;
  tap_st_e          tgt;
  logic             is_wait;
  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] left;
  logic             ltms;
  logic [SW-1:0]    steps;
  logic [2:0]       sync_cnt;
  logic [15:0]      row_cur;
  logic             at_tgt;

  assign row_cur = steer_row(cur);
  assign at_tgt  = (cur == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm <= F_IDLE; fin <= 1'b0; tgt <= TS_RESET; is_wait <= 1'b0;
      cyc <= '0; left <= '0; ltms <= 1'b0; steps <= '0; sync_cnt <= '0;
      err <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (fsm)
        F_IDLE: if (cmd_valid && !fin) begin
          tgt      <= tap_st_e'(cmd_target);
          is_wait  <= cmd_wait;
          cyc      <= cmd_cycles;
          err      <= 1'b0;
          sync_cnt <= '0;
          fsm      <= known ? F_CHECK : F_SYNC;
        end
        F_SYNC: fsm <= F_SYNC_W;
        F_SYNC_W: if (bit_end) begin
          if (sync_cnt == SYNC_LAST) fsm <= F_CHECK;
          else begin sync_cnt <= sync_cnt + 1'b1; fsm <= F_SYNC; end
        end
        F_CHECK: begin
          steps <= '0;
          if (!at_tgt) fsm <= F_ROUTE;
          else begin
            fsm <= F_LOOP;
            if (is_wait) begin
              left <= cyc; ltms <= (tgt == TS_RESET);
            end else if (holds_low(tgt)) begin
              left <= CYC_W'(1); ltms <= 1'b0;
            end else if (tgt == TS_RESET) begin
              left <= CYC_W'(1); ltms <= 1'b1;
            end else left <= '0;
          end
        end
        F_ROUTE: begin
          if (at_tgt) begin
            left <= is_wait ? cyc : '0;
            ltms <= (tgt == TS_RESET);
            fsm  <= F_LOOP;
          end else if (steps == STEP_CAP) begin
            err <= 1'b1;
            fin <= 1'b1;
            fsm <= F_IDLE;
          end else fsm <= F_ROUTE_W;
        end
        F_ROUTE_W: if (bit_end) begin steps <= steps + 1'b1; fsm <= F_ROUTE; end
        F_LOOP: begin
          if (left == '0) begin fin <= 1'b1; fsm <= F_IDLE; end
          else fsm <= F_LOOP_W;
        end
        default: if (bit_end) begin left <= left - 1'b1; fsm <= F_LOOP; end
      endcase
    end
  end

  always_comb begin
    bit_go  = 1'b0;
    bit_tms = 1'b0;
    case (fsm)
      F_SYNC:  begin bit_go = 1'b1; bit_tms = (sync_cnt != SYNC_LAST); end
      F_ROUTE: begin
        bit_go  = !at_tgt && (steps != STEP_CAP);
        bit_tms = row_cur[tgt];
      end
      F_LOOP:  begin bit_go = (left != '0); bit_tms = ltms; end
      default: ;
    endcase
  end

  assign mark_known = (fsm == F_SYNC_W) && bit_end && (sync_cnt == SYNC_LAST);
  assign done       = fin;
  assign busy       = (fsm != F_IDLE) || fin;

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_tck_in_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> busy);
  assert_step_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_ROUTE_W) |-> (steps < STEP_CAP));
  assert_go_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_go |-> !bit_busy);
endmodule

// File: rtl/tap_walker.sv
`timescale 1ns/1ps
module tap_walker
  import tap_walker_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int MAX_STEPS = 9,
  parameter int CYC_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_wait,
  input  logic [3:0]       cmd_target,
  input  logic [CYC_W-1:0] cmd_cycles,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             tck,
  output logic             tms,
  output logic             tdi
);
  tap_st_e cur;
  logic known, bit_go, bit_tms, bit_busy, bit_end, mark_known;

  tap_tck_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .bit_go(bit_go), .bit_tms(bit_tms),
    .tck(tck), .tms(tms), .bit_busy(bit_busy), .bit_end(bit_end)
  );

  tap_track u_track (
    .clk(clk), .rst_n(rst_n), .step(bit_end), .step_tms(tms),
    .mark_known(mark_known), .cur(cur), .known(known)
  );

  tap_seq #(.MAX_STEPS(MAX_STEPS), .CYC_W(CYC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wait(cmd_wait),
    .cmd_target(cmd_target), .cmd_cycles(cmd_cycles), .cur(cur),
    .known(known), .bit_end(bit_end), .bit_busy(bit_busy), .tck(tck),
    .bit_go(bit_go), .bit_tms(bit_tms), .mark_known(mark_known),
    .busy(busy), .done(done), .err(err)
  );

  assign tdi = 1'b0;
endmodule

// File: tb/test_tap_walker.sv
`timescale 1ns/1ps
module test_tap_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_wait = 0;
  logic [3:0] cmd_target = 0;
  logic [15:0] cmd_cycles = 0;
  logic busy, done, err, tck, tms, tdi;

  logic c2_valid = 0;
  logic [3:0] c2_target = 0;
  logic busy2, done2, err2, tck2, tms2, tdi2;

  tap_walker i_tap_walker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wait(cmd_wait),
    .cmd_target(cmd_target), .cmd_cycles(cmd_cycles), .busy(busy),
    .done(done), .err(err), .tck(tck), .tms(tms), .tdi(tdi)
  );

  tap_walker #(.MAX_STEPS(2)) i_tap_walker_lim (
    .clk(clk), .rst_n(rst_n), .cmd_valid(c2_valid), .cmd_wait(1'b0),
    .cmd_target(c2_target), .cmd_cycles(16'd0), .busy(busy2),
    .done(done2), .err(err2), .tck(tck2), .tms(tms2), .tdi(tdi2)
  );

  int n_chk = 0, n_bad = 0;
  int n_tck = 0, n_tck2 = 0, n_tdi_hi = 0, tms_hi_bad = 0, hi_bad = 0;
  logic [63:0] tms_log = '0;
  int model = 4;        // arbitrary power-up state of the modelled port
  time t_rise;

  // Independent TAP model: next state for TMS high / low.
  function automatic int m_next(int s, bit t);
    int hi[16] = '{0, 2, 9, 5, 5, 8, 7, 8, 2, 0, 12, 12, 15, 14, 15, 2};
    int lo[16] = '{1, 1, 3, 4, 4, 6, 6, 4, 1, 10, 11, 11, 13, 13, 11, 1};
    return t ? hi[s] : lo[s];
  endfunction

  always @(posedge tck) begin
    if (n_tck < 64) tms_log[n_tck] = tms;
    n_tck++;
    if (tdi) n_tdi_hi++;
    model = m_next(model, tms);
    t_rise = $time;
  end
  always @(negedge tck) if ($time - t_rise != 20) hi_bad++;
  always @(tms) if (tck) tms_hi_bad++;
  always @(posedge tck2) n_tck2++;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(bit w, int tgt, int cyc, bit chk_pulse);
    bit seen = 0;
    n_tck = 0; tms_log = '0;
    @(negedge clk);
    cmd_valid = 1; cmd_wait = w; cmd_target = 4'(tgt); cmd_cycles = 16'(cyc);
    @(negedge clk);
    cmd_valid = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    check(seen, "R11", "done seen", seen, 1);
    if (chk_pulse) begin
      @(negedge clk);
      check(!done, "R11", "done one cycle", done, 0);
    end
  endtask

  task automatic t_reset();
    check({tck, tms, tdi, busy, done, err} == 6'b0, "R12", "outputs after reset",
          {tck, tms, tdi, busy, done, err}, 0);
  endtask

  task automatic t_first_sync();   // R1 then R5 dwell in Idle
    run_cmd(0, 1, 0, 1);
    check(n_tck == 7, "R1", "tck count", n_tck, 7);
    check(tms_log[6:0] == 7'b0011111, "R1", "tms burst", tms_log[6:0], 7'b0011111);
    check(model == 1, "R1", "state", model, 1);
  endtask

  task automatic t_routes();
    run_cmd(0, 4, 0, 0);   // Idle -> Shift-DR
    check(n_tck == 3 && tms_log[2:0] == 3'b001, "R2", "to Shift-DR tms", tms_log[2:0], 1);
    check(model == 4, "R2", "state", model, 4);
    run_cmd(0, 4, 0, 0);   // stable dwell
    check(n_tck == 1 && tms_log[0] == 0, "R5", "Shift-DR dwell", n_tck, 1);
    run_cmd(0, 5, 0, 0);
    check(n_tck == 1 && tms_log[0] == 1 && model == 5, "R2", "to Exit1-DR", model, 5);
    run_cmd(0, 5, 0, 0);   // transient: no clock
    check(n_tck == 0 && model == 5, "R7", "Exit1-DR no clock", n_tck, 0);
    run_cmd(0, 0, 0, 0);
    check(n_tck == 4 && tms_log[3:0] == 4'hF, "R2", "to Reset", n_tck, 4);
    check(model == 0, "R2", "state", model, 0);
    run_cmd(0, 0, 0, 0);
    check(n_tck == 1 && tms_log[0] == 1 && model == 0, "R6", "Reset dwell", n_tck, 1);
  endtask

  task automatic t_waits();
    run_cmd(1, 13, 3, 0);  // route 6 then 3 low
    check(n_tck == 9, "R8", "wait Pause-IR count", n_tck, 9);
    check(tms_log[8:0] == 9'b000010110, "R8", "wait Pause-IR tms", tms_log[8:0], 9'b000010110);
    check(model == 13, "R8", "state", model, 13);
    run_cmd(1, 0, 4, 0);   // route 5 then 4 high
    check(n_tck == 9 && tms_log[8:0] == 9'h1FF, "R8", "wait Reset", tms_log[8:0], 9'h1FF);
    run_cmd(1, 0, 0, 0);
    check(n_tck == 0 && model == 0, "R8", "zero dwell", n_tck, 0);
  endtask

  task automatic t_sweep();
    for (int t = 0; t < 16; t++) begin
      run_cmd(0, t, 0, 0);
      check(model == t && n_tck <= 9 && !err, "R3", "sweep state", model, t);
    end
  endtask

  task automatic t_busy_ignore();  // from Update-IR, 4 steps to Shift-IR
    n_tck = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_wait = 0; cmd_target = 4'd11;
    @(negedge clk);
    cmd_target = 4'd1;
    check(busy, "R11", "busy after accept", busy, 1);
    @(negedge clk);
    cmd_valid = 0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    check(model == 11 && n_tck == 4 && !busy, "R11", "command while busy ignored", model, 11);
  endtask

  task automatic t_limit();
    @(negedge clk);
    c2_valid = 1; c2_target = 4'd11;
    @(negedge clk);
    c2_valid = 0;
    for (int i = 0; i < 2000 && !done2; i++) @(negedge clk);
    check(err2 && done2, "R4", "error at limit", err2, 1);
    check(n_tck2 == 8, "R4", "tck before giving up", n_tck2, 8);
    n_tck2 = 0;
    @(negedge clk);
    c2_valid = 1; c2_target = 4'd9;   // already in Select-IR
    @(negedge clk);
    c2_valid = 0;
    for (int i = 0; i < 2000 && !done2; i++) @(negedge clk);
    check(!err2 && n_tck2 == 0, "R4", "error cleared", err2, 0);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_first_sync();
    t_routes();
    t_waits();
    t_sweep();
    t_busy_ignore();
    t_limit();
    check(n_tdi_hi == 0, "R9", "tdi high at tck edge", n_tdi_hi, 0);
    check(tms_hi_bad == 0, "R10", "tms moved with tck high", tms_hi_bad, 0);
    check(hi_bad == 0, "R10", "tck high width", hi_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule